// File: doc/BRIEF.md
# Timer Match Output and DMA Request Stage

This stage sits behind the compare logic of a timer and turns its per-channel match pulses into external output levels. Each of the output pins has its own two-bit action code. The code chooses what a match pulse does to that pin: leave it alone, force it low, force it high or invert it. Software may also load all pin levels directly. A direct load takes priority over any match action in the same cycle.

The lowest output channels also drive DMA request lines. A request is raised whenever the level of its pin goes from 0 to 1, whether a match or a direct load caused the change. The request then stays up until the interrupt-flag clear strobe for that match channel arrives. A new rise in the same cycle as a clear keeps the request asserted.

Top module: `match_out_stage`

## Requirements
- R1: While `rst` is high at a rising clock edge, all pins, both DMA requests and all action codes go to 0 from that edge on.
- R2: Action code 0 (bits [2i+1:2i] of the action register for pin i) leaves pin i unchanged when its match pulse arrives.
- R3: Action code 1 drives pin i to 0 at the clock edge where its match pulse is sampled.
- R4: Action code 2 drives pin i to 1 at the clock edge where its match pulse is sampled.
- R5: Action code 3 inverts pin i at the clock edge where its match pulse is sampled.
- R6: A pin whose match pulse is low and that is not being loaded keeps its level.
- R7: `level_wr` loads `level_wdata` into all pins at the next edge, and it overrides any match action in that cycle.
- R8: `action_wr` stores `action_wdata`, which is read back on `action_rd` from the next cycle. A match in the same cycle as the write uses the old code.
- R9: DMA request j (j = 0, 1) rises at the same edge as pin j makes a 0-to-1 transition.
- R10: A DMA request stays high until `flag_clr[j]` is sampled high, and then it drops at that edge.
- R11: When a 0-to-1 transition of pin j and `flag_clr[j]` fall in the same cycle, request j stays high.
- R12: Pins 2 and 3 never raise a request. A pin that stays at 1 raises no new request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| match_pulse | input | 4 | One-cycle match strobe per output channel |
| action_wr | input | 1 | Write strobe for the action register |
| action_wdata | input | 8 | Two-bit action code per pin |
| level_wr | input | 1 | Direct load strobe for the pin levels |
| level_wdata | input | 4 | Levels to load |
| flag_clr | input | 2 | Match interrupt-flag clear strobes for channels 0 and 1 |
| pin_out | output | 4 | Current output levels, also the readable output bits |
| action_rd | output | 8 | Action register readback |
| dma_req | output | 2 | DMA request lines for channels 0 and 1 |

## Verification
Two pairs of functions can fall in the same cycle. The first pair is a direct level load and a match pulse on the same pin. The second pair is a request-raising rise and the clear strobe of that same request. The stimulus table drives each pair in a single cycle: a toggle match together with a clear, and a load together with a toggle match. The bench then checks that the load wins and that the request survives the clear. A directed case also writes new action codes in the same cycle as a match, and it confirms that the old code acts on that match and the new code acts on the next one.

// File: rtl/match_out_pkg.sv
package match_out_pkg;

    typedef enum logic [1:0] {
        ACT_HOLD   = 2'd0,
        ACT_LOW    = 2'd1,
        ACT_HIGH   = 2'd2,
        ACT_INVERT = 2'd3
    } match_act_t;

    localparam int ACT_W = 2;

    // Level that a match pulse produces from the current level
    function automatic logic apply_act(input match_act_t act, input logic cur);
        logic res;
        case (act)
            ACT_LOW:    res = 1'b0;
            ACT_HIGH:   res = 1'b1;
            ACT_INVERT: res = ~cur;
            default:    res = cur;
        endcase
        return res;
    endfunction

endpackage

// File: rtl/match_act_cfg.sv
module match_act_cfg
    import match_out_pkg::*;
#(
    parameter int NUM_OUT = 4,
    localparam int CFG_W  = NUM_OUT * ACT_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr,
    input  logic [CFG_W-1:0] wdata,
    output logic [CFG_W-1:0] cfg_q
);

    always_ff @(posedge clk) begin
        if (rst)
            cfg_q <= '0;
        else if (wr)
            cfg_q <= wdata;
    end

    // R8
    cfg_load_chk: assert property (@(posedge clk) disable iff (rst)
        wr |=> cfg_q == $past(wdata));

    // R8
    cfg_keep_chk: assert property (@(posedge clk) disable iff (rst)
        !wr |=> $stable(cfg_q));

endmodule

// File: rtl/match_pin_cell.sv
module match_pin_cell
    import match_out_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       match,
    input  match_act_t act,
    input  logic       load,
    input  logic       load_val,
    output logic       pin_q,
    output logic       pin_nxt
);

    always_comb begin
        if (load)
            pin_nxt = load_val;
        else if (match)
            pin_nxt = apply_act(act, pin_q);
        else
            pin_nxt = pin_q;
    end

    always_ff @(posedge clk) begin
        if (rst)
            pin_q <= 1'b0;
        else
            pin_q <= pin_nxt;
    end

    // R3
    act_low_chk: assert property (@(posedge clk) disable iff (rst)
        (match && !load && act == ACT_LOW) |=> !pin_q);

    // R4
    act_high_chk: assert property (@(posedge clk) disable iff (rst)
        (match && !load && act == ACT_HIGH) |=> pin_q);

    // R5
    act_inv_chk: assert property (@(posedge clk) disable iff (rst)
        (match && !load && act == ACT_INVERT) |=> pin_q != $past(pin_q));

    // R6
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!match && !load) |=> $stable(pin_q));

    // R7
    load_wins_chk: assert property (@(posedge clk) disable iff (rst)
        load |=> pin_q == $past(load_val));

endmodule

// File: rtl/match_dma_req.sv
module match_dma_req (
    input  logic clk,
    input  logic rst,
    input  logic pin_q,
    input  logic pin_nxt,
    input  logic clr,
    output logic req
);

    logic rise;
    assign rise = pin_nxt & ~pin_q;

    always_ff @(posedge clk) begin
        if (rst)
            req <= 1'b0;
        else if (rise)
            req <= 1'b1;
        else if (clr)
            req <= 1'b0;
    end

    // R9
    req_set_chk: assert property (@(posedge clk) disable iff (rst)
        rise |=> req && pin_q);

    // R10
    req_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (req && !clr) |=> req);

    // R10
    req_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (clr && !rise) |=> !req);

    // R12
    req_no_spur_chk: assert property (@(posedge clk) disable iff (rst)
        (!req && !rise) |=> !req);

endmodule

// File: rtl/match_out_stage.sv
module match_out_stage
    import match_out_pkg::*;
#(
    parameter int NUM_OUT = 4,
    parameter int NUM_DMA = 2,
    localparam int CFG_W  = NUM_OUT * ACT_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_OUT-1:0] match_pulse,
    input  logic               action_wr,
    input  logic [CFG_W-1:0]   action_wdata,
    input  logic               level_wr,
    input  logic [NUM_OUT-1:0] level_wdata,
    input  logic [NUM_DMA-1:0] flag_clr,
    output logic [NUM_OUT-1:0] pin_out,
    output logic [CFG_W-1:0]   action_rd,
    output logic [NUM_DMA-1:0] dma_req
);

    logic [CFG_W-1:0]   cfg_q;
    logic [NUM_OUT-1:0] pin_nxt;

    match_act_cfg #(.NUM_OUT(NUM_OUT)) u_cfg (
        .clk   (clk),
        .rst   (rst),
        .wr    (action_wr),
        .wdata (action_wdata),
        .cfg_q (cfg_q)
    );

    assign action_rd = cfg_q;

    for (genvar i = 0; i < NUM_OUT; i++) begin : g_pin
        match_pin_cell u_cell (
            .clk      (clk),
            .rst      (rst),
            .match    (match_pulse[i]),
            .act      (match_act_t'(cfg_q[i*ACT_W +: ACT_W])),
            .load     (level_wr),
            .load_val (level_wdata[i]),
            .pin_q    (pin_out[i]),
            .pin_nxt  (pin_nxt[i])
        );
    end

    for (genvar j = 0; j < NUM_DMA; j++) begin : g_dma
        match_dma_req u_req (
            .clk     (clk),
            .rst     (rst),
            .pin_q   (pin_out[j]),
            .pin_nxt (pin_nxt[j]),
            .clr     (flag_clr[j]),
            .req     (dma_req[j])
        );
    end

    // R1
    rst_clear_chk: assert property (@(posedge clk)
        rst |=> (pin_out == '0 && dma_req == '0 && action_rd == '0));

    // R11
    rise_beats_clr_chk: assert property (@(posedge clk) disable iff (rst)
        (flag_clr[0] && pin_nxt[0] && !pin_out[0]) |=> dma_req[0]);

endmodule

// File: tb/match_out_stage_test.sv
module match_out_stage_test;

    localparam int CLK_PERIOD = 10;
    localparam int NV = 14;

    logic       clk = 1'b0;
    logic       rst;
    logic [3:0] match_pulse;
    logic       action_wr;
    logic [7:0] action_wdata;
    logic       level_wr;
    logic [3:0] level_wdata;
    logic [1:0] flag_clr;
    logic [3:0] pin_out;
    logic [7:0] action_rd;
    logic [1:0] dma_req;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    match_out_stage uut (
        .clk          (clk),
        .rst          (rst),
        .match_pulse  (match_pulse),
        .action_wr    (action_wr),
        .action_wdata (action_wdata),
        .level_wr     (level_wr),
        .level_wdata  (level_wdata),
        .flag_clr     (flag_clr),
        .pin_out      (pin_out),
        .action_rd    (action_rd),
        .dma_req      (dma_req)
    );

    // Vector: match[16:13] lwr[12] ldata[11:8] clr[7:6] exp_pin[5:2] exp_dma[1:0]
    // Actions in force: pin0 high(2), pin1 invert(3), pin2 low(1), pin3 hold(0)
    localparam logic [16:0] VEC [NV] = '{
        {4'b0001, 1'b0, 4'b0000, 2'b00, 4'b0001, 2'b01}, // R4 R9
        {4'b0010, 1'b0, 4'b0000, 2'b00, 4'b0011, 2'b11}, // R5 R9
        {4'b0010, 1'b0, 4'b0000, 2'b00, 4'b0001, 2'b11}, // R5 R10
        {4'b0000, 1'b0, 4'b0000, 2'b01, 4'b0001, 2'b10}, // R10
        {4'b0001, 1'b0, 4'b0000, 2'b00, 4'b0001, 2'b10}, // R12
        {4'b0000, 1'b1, 4'b1100, 2'b00, 4'b1100, 2'b10}, // R7
        {4'b1100, 1'b0, 4'b0000, 2'b00, 4'b1000, 2'b10}, // R2 R3
        {4'b0000, 1'b0, 4'b0000, 2'b10, 4'b1000, 2'b00}, // R10
        {4'b0010, 1'b0, 4'b0000, 2'b10, 4'b1010, 2'b10}, // R11
        {4'b0010, 1'b1, 4'b0111, 2'b00, 4'b0111, 2'b11}, // R7 R9
        {4'b0000, 1'b0, 4'b0000, 2'b00, 4'b0111, 2'b11}, // R6
        {4'b0000, 1'b1, 4'b0100, 2'b11, 4'b0100, 2'b00}, // R10
        {4'b0100, 1'b0, 4'b0000, 2'b00, 4'b0000, 2'b00}, // R3
        {4'b0000, 1'b1, 4'b1100, 2'b00, 4'b1100, 2'b00}  // R12
    };

    task automatic check(input string req, input string what,
                         input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic idle_inputs();
        match_pulse  = '0;
        action_wr    = 1'b0;
        action_wdata = '0;
        level_wr     = 1'b0;
        level_wdata  = '0;
        flag_clr     = '0;
    endtask

    // Inputs are driven at a falling edge, sampled at the next falling edge
    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        idle_inputs();
        rst = 1'b1;
        @(negedge clk);
        step();
        rst = 1'b0;
        check("R1", "pins", {4'b0, pin_out}, 8'h00);
        check("R1", "dma", {6'b0, dma_req}, 8'h00);
        check("R1", "actions", action_rd, 8'h00);

        // R2: default hold code, all matches leave pins low
        match_pulse = 4'b1111;
        step();
        idle_inputs();
        check("R2", "pins hold", {4'b0, pin_out}, 8'h00);

        // R8: action register write and readback
        action_wr    = 1'b1;
        action_wdata = 8'b00_01_11_10;
        step();
        idle_inputs();
        check("R8", "action_rd", action_rd, 8'h1E);

        for (int v = 0; v < NV; v++) begin
            match_pulse = VEC[v][16:13];
            level_wr    = VEC[v][12];
            level_wdata = VEC[v][11:8];
            flag_clr    = VEC[v][7:6];
            step();
            idle_inputs();
            check($sformatf("R-vec%0d", v), "pins", {4'b0, pin_out}, {4'b0, VEC[v][5:2]});
            check($sformatf("R-vec%0d", v), "dma", {6'b0, dma_req}, {6'b0, VEC[v][1:0]});
        end

        // R8: same-cycle write uses old code on pin3 (hold), new code invert
        action_wr    = 1'b1;
        action_wdata = 8'hFF;
        match_pulse  = 4'b1000;
        step();
        idle_inputs();
        check("R8", "old code on match", {4'b0, pin_out}, 8'h0C);
        check("R8", "action_rd new", action_rd, 8'hFF);
        match_pulse = 4'b1000;
        step();
        idle_inputs();
        check("R8", "new code on match", {4'b0, pin_out}, 8'h04);

        // R9: rise on pin0 via invert sets request
        match_pulse = 4'b0001;
        step();
        idle_inputs();
        check("R9", "dma after invert rise", {6'b0, dma_req}, 8'h01);

        // R1: reset mid-run with activity
        rst         = 1'b1;
        match_pulse = 4'b1111;
        step();
        rst = 1'b0;
        idle_inputs();
        check("R1", "pins after reset", {4'b0, pin_out}, 8'h00);
        check("R1", "dma after reset", {6'b0, dma_req}, 8'h00);
        check("R1", "actions after reset", action_rd, 8'h00);

        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule